// File: doc/BRIEF.md
# UART Interrupt Prioritizer with Modem Status Tracking

This unit gathers the four interrupt conditions of an asynchronous serial port: receive line error status, received data available, transmit holding register empty, and a change on the modem handshake lines. Each condition passes through a four-bit enable mask held in a small enable register. The highest-priority surviving condition is reported in an 8-bit identification word. The same conditions drive an interrupt line, and a modem-control bit can switch that line to high impedance.

The unit also keeps the modem status register. Its upper four bits show the present level of the clear-to-send, data-set-ready, ring and carrier lines. Its lower four bits are sticky change flags, which are cleared when software reads the register. In loopback mode the four external lines are ignored, and the four modem-control output bits take their place. Address decoding and the serial shift paths are outside this unit: the surrounding port controller supplies read and write strobes and level status signals.

Top module: `uart_irq_modem_unit`

## Requirements
- R1: Writing `ier_wdata` with `ier_we` high loads bits 3:0 into the enable register on that clock edge. Bit 0 enables received data, bit 1 enables transmit empty, bit 2 enables line status and bit 3 enables modem status. `ier_rdata[7:4]` always read 0, and `ier_rdata` is 0 after reset.
- R2: Only enabled conditions compete. The fixed priority is line status (`iid[2:1]`=11), then received data (10), then transmit empty (01), then modem status (00). `iid[2:1]` gives the code of the highest enabled pending condition.
- R3: `iid[0]` is 0 while any enabled condition is pending and 1 when none is. `iid[7:3]` are always 0, so the idle word is 8'h01.
- R4: Delta bits `msr[0]` (CTS), `msr[1]` (DSR) and `msr[3]` (CD) become 1 one cycle after their line's effective state differs from the registered state, in either direction.
- R5: Delta bit `msr[2]` (RI) becomes 1 only when the ring state falls from 1 to 0, that is when `ri_n` rises from low to high. A rise of the ring state leaves the bit unchanged.
- R6: A one-cycle `msr_rd` pulse clears all four delta bits on the next edge. If a line changes in that same cycle, its delta bit is set.
- R7: The modem status condition is pending exactly when at least one of `msr[3:0]` is 1.
- R8: State bits `msr[4]`..`msr[7]` are the registered complements of `cts_n`, `dsr_n`, `ri_n` and `cd_n`. They lag the lines by one cycle. With `loopback` high they take `mcr_rts`, `mcr_dtr`, `mcr_out1` and `mcr_out2` instead.
- R9: The transmit-empty condition sets one cycle after `thr_empty` rises, unless `thr_wr` is high in that cycle. It clears after a `thr_wr` pulse. It also clears after an `iid_rd` pulse taken while `iid[3:0]` shows 4'b0010. It stays set when read while a higher source is shown.
- R10: `int_o` is 1 exactly when `iid[0]` is 0. `int_oe` follows `mcr_out2`, and the pin is at high impedance while it is 0.
- R11: After reset `msr` reads 8'h00, `iid` reads 8'h01 and `int_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_we | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register read value |
| lsr_irq | input | 1 | Line status error condition (level) |
| rxd_irq | input | 1 | Received data available (level) |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| thr_wr | input | 1 | Transmit holding register write pulse |
| iid_rd | input | 1 | Identification word read pulse |
| msr_rd | input | 1 | Modem status read pulse |
| loopback | input | 1 | Loopback mode select |
| mcr_dtr | input | 1 | Modem-control DTR bit |
| mcr_rts | input | 1 | Modem-control RTS bit |
| mcr_out1 | input | 1 | Modem-control spare output bit |
| mcr_out2 | input | 1 | Modem-control OUT2 / interrupt output enable |
| cts_n | input | 1 | Clear-to-send line, active low |
| dsr_n | input | 1 | Data-set-ready line, active low |
| ri_n | input | 1 | Ring indicator line, active low |
| cd_n | input | 1 | Carrier detect line, active low |
| iid | output | 8 | Interrupt identification word |
| msr | output | 8 | Modem status register |
| int_o | output | 1 | Interrupt level |
| int_oe | output | 1 | Interrupt pad output enable |

## Verification
Three cases are hard to reach from the ports. In the first, a delta bit is both cleared by a read and set again by a line change in the same clock. In the second, the transmit-empty condition is read while a higher source hides it, so it must survive that read. In the third, the stimulus enters loopback while the control bits differ from the external lines, so the switch itself counts as a change. The stimulus drives these overlaps directly, in single cycles. After that, a long phase changes all inputs pseudo-randomly, with read pulses spread among them. A behavioural model in the bench is compared against every output on every cycle.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC  = 4;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    SRC_MSR = 2'b00,
    SRC_THR = 2'b01,
    SRC_RXD = 2'b10,
    SRC_LSR = 2'b11
  } irq_src_e;
endpackage

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg #(
  parameter int REG_W = 8,
  parameter int NSRC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [NSRC-1:0]  en_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam int PAD_W = REG_W - NSRC;

  logic [NSRC-1:0] en_q, en_d;

  always_comb begin
    en_d = wdata[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (we) en_q <= en_d;
  end

  assign en_o    = en_q;
  assign rdata_o = {{PAD_W{1'b0}}, en_q};

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(en_q));
  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata_o == {{PAD_W{1'b0}}, $past(wdata[NSRC-1:0])}));
endmodule

// File: rtl/uirq_modem_status.sv
module uirq_modem_status #(
  parameter int NLINES = 4,
  parameter int RI_IDX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loopback,
  input  logic [NLINES-1:0] line_n,
  input  logic [NLINES-1:0] ctrl,
  input  logic              rd,
  output logic [NLINES-1:0] state_o,
  output logic [NLINES-1:0] delta_o,
  output logic              change_o
);
  logic [NLINES-1:0] eff, set_vec;
  logic [NLINES-1:0] state_q, state_d;
  logic [NLINES-1:0] delta_q, delta_d;
  logic              delta_en;

  always_comb begin
    eff = loopback ? ctrl : ~line_n;
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    if (i == RI_IDX) begin : g_trail
      assign set_vec[i] = state_q[i] & ~eff[i];
    end else begin : g_any
      assign set_vec[i] = state_q[i] ^ eff[i];
    end
  end

  always_comb begin
    state_d  = eff;
    delta_d  = (rd ? '0 : delta_q) | set_vec;
    delta_en = rd | (|set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      delta_q <= '0;
    end else begin
      state_q <= state_d;
      if (delta_en) delta_q <= delta_d;
    end
  end

  assign state_o  = state_q;
  assign delta_o  = delta_q;
  assign change_o = |delta_q;

  a_r4_cts_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (eff[0] != state_q[0]) |=> delta_q[0]);
  a_r5_ri_trail: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q[RI_IDX] && !eff[RI_IDX]) |=> delta_q[RI_IDX]);
  a_r5_ri_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (!delta_q[RI_IDX] && !rd && (eff[RI_IDX] || !state_q[RI_IDX])) |=> !delta_q[RI_IDX]);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (eff == state_q)) |=> (delta_q == '0));
endmodule

// File: rtl/uirq_thre_tracker.sv
module uirq_thre_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_empty,
  input  logic thr_wr,
  input  logic iid_rd,
  input  logic thr_top,
  output logic pend_o
);
  logic empty_q, pend_q, pend_d, rise;

  always_comb begin
    rise   = thr_empty & ~empty_q;
    pend_d = pend_q;
    if (rise && !thr_wr)                pend_d = 1'b1;
    else if (thr_wr || (iid_rd && thr_top)) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      empty_q <= thr_empty;
      pend_q  <= pend_d;
    end
  end

  assign pend_o = pend_q;

  a_r9_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !pend_q);
  a_r9_hidden_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && iid_rd && !thr_top && !thr_wr) |=> pend_q);
endmodule

// File: rtl/uirq_priority.sv
module uirq_priority #(
  parameter int NSRC  = 4,
  parameter int REG_W = 8
) (
  input  logic [NSRC-1:0]          req,
  output logic [REG_W-1:0]         iid_o,
  output logic                     pending_o,
  output logic [$clog2(NSRC)-1:0]  top_o
);
  localparam int CODE_W = $clog2(NSRC);
  localparam int PAD_W  = REG_W - CODE_W - 1;

  logic [CODE_W-1:0] code;

  always_comb begin
    code = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i]) code = CODE_W'(i);
    end
  end

  assign pending_o = |req;
  assign top_o     = code;
  assign iid_o     = {{PAD_W{1'b0}}, code, ~pending_o};

  always_comb begin
    a_r2_top_wins: assert (!req[NSRC-1] || (iid_o[CODE_W:1] == CODE_W'(NSRC-1)));
    a_r3_idle_word: assert (|req || (iid_o == REG_W'(1)));
  end
endmodule

// File: rtl/uart_irq_modem_unit.sv
module uart_irq_modem_unit
  import uirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ier_we,
  input  logic [7:0] ier_wdata,
  output logic [7:0] ier_rdata,
  input  logic       lsr_irq,
  input  logic       rxd_irq,
  input  logic       thr_empty,
  input  logic       thr_wr,
  input  logic       iid_rd,
  input  logic       msr_rd,
  input  logic       loopback,
  input  logic       mcr_dtr,
  input  logic       mcr_rts,
  input  logic       mcr_out1,
  input  logic       mcr_out2,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       cd_n,
  output logic [7:0] iid,
  output logic [7:0] msr,
  output logic       int_o,
  output logic       int_oe
);
  localparam int CODE_W = $clog2(NSRC);

  logic [NSRC-1:0]   en;
  logic [NSRC-1:0]   req;
  logic [NSRC-1:0]   mstate, mdelta;
  logic              mchange, thre_pend, pending;
  logic [CODE_W-1:0] top;
  logic              thr_top;

  uirq_enable_reg #(.REG_W(REG_W), .NSRC(NSRC)) u_en (
    .clk(clk), .rst_n(rst_n), .we(ier_we), .wdata(ier_wdata),
    .en_o(en), .rdata_o(ier_rdata));

  uirq_modem_status #(.NLINES(NSRC), .RI_IDX(2)) u_msr (
    .clk(clk), .rst_n(rst_n), .loopback(loopback),
    .line_n({cd_n, ri_n, dsr_n, cts_n}),
    .ctrl({mcr_out2, mcr_out1, mcr_dtr, mcr_rts}),
    .rd(msr_rd), .state_o(mstate), .delta_o(mdelta), .change_o(mchange));

  always_comb begin
    req[SRC_LSR] = lsr_irq   & en[2];
    req[SRC_RXD] = rxd_irq   & en[0];
    req[SRC_THR] = thre_pend & en[1];
    req[SRC_MSR] = mchange   & en[3];
    thr_top      = pending && (top == SRC_THR);
  end

  uirq_thre_tracker u_thre (
    .clk(clk), .rst_n(rst_n), .thr_empty(thr_empty), .thr_wr(thr_wr),
    .iid_rd(iid_rd), .thr_top(thr_top), .pend_o(thre_pend));

  uirq_priority #(.NSRC(NSRC), .REG_W(REG_W)) u_pri (
    .req(req), .iid_o(iid), .pending_o(pending), .top_o(top));

  assign msr    = {mstate, mdelta};
  assign int_o  = pending;
  assign int_oe = mcr_out2;

  a_r7_modem_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (en == 4'b1000 && msr[3:0] != 4'b0000) |-> (iid[3:0] == 4'b0000));
  a_r10_int_level: assert property (@(posedge clk) disable iff (!rst_n)
    int_o == !iid[0]);
endmodule

// File: tb/uart_irq_modem_unit_tb.sv
`timescale 1ns/1ps
module uart_irq_modem_unit_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic ier_we, thr_empty, thr_wr, iid_rd, msr_rd, loopback;
  logic [7:0] ier_wdata;
  logic lsr_irq, rxd_irq, mcr_dtr, mcr_rts, mcr_out1, mcr_out2;
  logic cts_n, dsr_n, ri_n, cd_n;
  logic [7:0] ier_rdata, iid, msr;
  logic int_o, int_oe;
  wire  int_pad;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign int_pad = int_oe ? int_o : 1'bz;

  uart_irq_modem_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ier_we(ier_we), .ier_wdata(ier_wdata),
    .ier_rdata(ier_rdata), .lsr_irq(lsr_irq), .rxd_irq(rxd_irq),
    .thr_empty(thr_empty), .thr_wr(thr_wr), .iid_rd(iid_rd), .msr_rd(msr_rd),
    .loopback(loopback), .mcr_dtr(mcr_dtr), .mcr_rts(mcr_rts),
    .mcr_out1(mcr_out1), .mcr_out2(mcr_out2), .cts_n(cts_n), .dsr_n(dsr_n),
    .ri_n(ri_n), .cd_n(cd_n), .iid(iid), .msr(msr), .int_o(int_o),
    .int_oe(int_oe));

  // behavioural reference state
  bit [3:0] m_en, m_state, m_delta;
  bit       m_thre, m_empty_prev;

  function automatic bit [3:0] m_eff();
    if (loopback) return {mcr_out2, mcr_out1, mcr_dtr, mcr_rts};
    return ~{cd_n, ri_n, dsr_n, cts_n};
  endfunction

  function automatic bit [7:0] m_iid();
    bit [7:0] w = 8'h01;
    if (m_en[3] && m_delta != 0) w = 8'h00;
    if (m_en[1] && m_thre)       w = 8'h02;
    if (m_en[0] && rxd_irq)      w = 8'h04;
    if (m_en[2] && lsr_irq)      w = 8'h06;
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_state = 0; m_delta = 0; m_thre = 0; m_empty_prev = 0;
    end else begin
      bit [3:0] e, s;
      bit top_thr;
      e = m_eff();
      top_thr = (m_iid() == 8'h02);
      s[0] = e[0] != m_state[0];
      s[1] = e[1] != m_state[1];
      s[3] = e[3] != m_state[3];
      s[2] = m_state[2] && !e[2];
      m_delta = (msr_rd ? 4'b0 : m_delta) | s;
      m_state = e;
      if (thr_empty && !m_empty_prev && !thr_wr) m_thre = 1;
      else if (thr_wr || (iid_rd && top_thr))   m_thre = 0;
      m_empty_prev = thr_empty;
      if (ier_we) m_en = ier_wdata[3:0];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic exp_pad;
    chk(ier_rdata === {4'b0, m_en}, "R1 enable readback", ier_rdata, {4'b0, m_en});
    chk(iid === m_iid(), "R2 R3 R7 R9 identification", iid, m_iid());
    chk(msr[3:0] === m_delta, "R4 R5 R6 delta bits", {4'b0, msr[3:0]}, {4'b0, m_delta});
    chk(msr[7:4] === m_state, "R8 state bits", {4'b0, msr[7:4]}, {4'b0, m_state});
    exp_pad = mcr_out2 ? (m_iid() != 8'h01) : 1'bz;
    chk(int_pad === exp_pad && int_o === (m_iid() != 8'h01), "R10 interrupt pin",
        {6'b0, int_oe, int_o}, {6'b0, mcr_out2, m_iid() != 8'h01});
  endtask

  // one cycle: inputs set by caller after negedge, compare after settle
  task automatic settle();
    #1 compare_all();
  endtask

  task automatic nxt();
    @(negedge clk);
    ier_we = 0; thr_wr = 0; iid_rd = 0; msr_rd = 0;
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    #1.5 compare_all();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 8'h00, 8'h01);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit [15:0] lf;
    rst_n = 0; ier_we = 0; ier_wdata = 0; lsr_irq = 0; rxd_irq = 0;
    thr_empty = 0; thr_wr = 0; iid_rd = 0; msr_rd = 0; loopback = 0;
    mcr_dtr = 0; mcr_rts = 0; mcr_out1 = 0; mcr_out2 = 1;
    cts_n = 1; dsr_n = 1; ri_n = 1; cd_n = 1;
    repeat (3) @(posedge clk);
    #1;
    chk(msr === 8'h00, "R11 reset msr", msr, 8'h00);
    chk(iid === 8'h01, "R11 reset iid", iid, 8'h01);
    chk(int_o === 1'b0, "R11 reset int", {7'b0, int_o}, 8'h00);
    chk(ier_rdata === 8'h00, "R1 reset enable", ier_rdata, 8'h00);
    @(negedge clk) rst_n = 1;

    // R1: write with upper bits set
    nxt(); ier_we = 1; ier_wdata = 8'hFF;
    nxt(); #1 chk(ier_rdata === 8'h0F, "R1 upper bits zero", ier_rdata, 8'h0F);

    // R2 priority ladder
    nxt(); lsr_irq = 1; rxd_irq = 1;
    #1 chk(iid === 8'h06, "R2 line status top", iid, 8'h06);
    nxt(); lsr_irq = 0;
    #1 chk(iid === 8'h04, "R2 rx data next", iid, 8'h04);
    nxt(); rxd_irq = 0;

    // R4 CTS fall, R6 read with simultaneous change
    nxt(); cts_n = 0;
    nxt(); #1 chk(msr[0] === 1'b1, "R4 cts delta", msr, 8'h11);
    chk(iid === 8'h00, "R7 modem source", iid, 8'h00);
    nxt(); msr_rd = 1; dsr_n = 0;
    nxt(); #1 chk(msr[3:0] === 4'b0010, "R6 clear with new change", msr, 8'h32);
    nxt(); msr_rd = 1;
    nxt(); #1 chk(msr[3:0] === 4'b0000, "R6 clear", msr, 8'h30);

    // R5 ring: assert (no delta) then release (delta)
    nxt(); ri_n = 0;
    nxt(); nxt(); #1 chk(msr[2] === 1'b0, "R5 ring leading ignored", msr, 8'h70);
    nxt(); ri_n = 1;
    nxt(); #1 chk(msr[2] === 1'b1, "R5 ring trailing", msr, 8'h34);
    nxt(); msr_rd = 1; cd_n = 0;
    nxt(); nxt(); msr_rd = 1;

    // R8 loopback substitution
    nxt(); loopback = 1; mcr_rts = 1; mcr_dtr = 0; mcr_out1 = 1; mcr_out2 = 1;
    nxt(); #1 chk(msr[7:4] === 4'b1101, "R8 loopback state", msr, 8'hD0);
    nxt(); cts_n = 1; dsr_n = 1;
    nxt(); #1 chk(msr[7:4] === 4'b1101, "R8 lines ignored in loopback", msr, 8'hD0);
    nxt(); msr_rd = 1; nxt(); loopback = 0;

    // R9 transmit empty
    nxt(); msr_rd = 1; nxt(); msr_rd = 1;
    nxt(); thr_empty = 1;
    nxt(); #1 chk(iid === 8'h02, "R9 thr empty sets", iid, 8'h02);
    nxt(); lsr_irq = 1; iid_rd = 1;
    nxt(); lsr_irq = 0; #1 chk(iid === 8'h02, "R9 hidden read keeps", iid, 8'h02);
    nxt(); iid_rd = 1;
    nxt(); #1 chk(iid === 8'h01, "R9 top read clears", iid, 8'h01);
    nxt(); thr_empty = 0; nxt(); thr_empty = 1;
    nxt(); thr_wr = 1; thr_empty = 0;
    nxt(); #1 chk(iid === 8'h01, "R9 write clears", iid, 8'h01);

    // R10 tristate
    nxt(); rxd_irq = 1; mcr_out2 = 0;
    #1 chk(int_pad === 1'bz, "R10 pad tristate", {7'b0, int_oe}, 8'h00);
    nxt(); mcr_out2 = 1;
    #1 chk(int_pad === 1'b1, "R10 pad driven", {7'b0, int_pad}, 8'h01);

    // pseudo-random phase
    lf = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      nxt();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      lsr_irq = lf[0] & lf[5]; rxd_irq = lf[1];
      thr_empty = lf[2] | lf[9]; thr_wr = lf[3] & lf[7] & lf[11];
      iid_rd = lf[4] & lf[8]; msr_rd = lf[6] & lf[12];
      ier_we = (lf[15:13] == 3'b101); ier_wdata = {lf[3:0], lf[11:8]};
      loopback = lf[13] & lf[14];
      mcr_rts = lf[1]; mcr_dtr = lf[8]; mcr_out1 = lf[10]; mcr_out2 = lf[15] | lf[3];
      if (lf[2:0] == 3'd3) cts_n = ~cts_n;
      if (lf[5:3] == 3'd5) dsr_n = ~dsr_n;
      if (lf[8:6] == 3'd1) ri_n  = ~ri_n;
      if (lf[11:9] == 3'd6) cd_n = ~cd_n;
    end
    nxt(); nxt();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule